// File: doc/BRIEF.md
# Iterative Restoring Divider with Ready/Valid Handshakes

This block divides an unsigned dividend by an unsigned divisor over several clock cycles, producing one quotient bit per cycle. A request carries the dividend `a`, the divisor `b` and a per-request length `nbits`. Only the low `nbits` bits of `a` take part, and the quotient is `nbits` bits wide. The request is taken through a valid/ready pair. The quotient is returned through a second valid/ready pair, so the consumer can hold it off for as long as it likes.

A three-state controller (idle, running, result held) sequences the work. A separate datapath keeps the dividend shift register, the divisor, the partial remainder and the quotient shift register. On each running cycle the datapath moves the next dividend bit, most significant first, into the partial remainder. If the result is at least the divisor, it subtracts the divisor and records a 1. Otherwise it records a 0.

Top module: `divu_core`

## Requirements
- R1: While `rst` is high at a clock edge, the block goes idle. After that edge `inReady`=1, `outValid`=0 and `z`=0.
- R2: A request is taken only at an edge where `inReady` and `inValid` are both 1. While the block is busy, changes on `a`, `b`, `nbits` and `inValid` have no effect on the result it returns.
- R3: For `b`≠0 the returned `z` equals floor((`a` mod 2^n) / `b`), where n is the effective length. Bits of `z` at position n and above are 0.
- R4: After the accepting edge, `outValid` first reads 1 after exactly n+1 edges when n≥1, and after 1 edge when n=0. When n=0, `z` is 0.
- R5: Once `outValid` is 1, it and `z` stay unchanged until an edge with `outReady`=1. `inReady` is 0 from the accepting edge until that edge.
- R6: On the edge where `outValid` and `outReady` are both 1, the block goes idle. From the next cycle `inReady`=1 and `outValid`=0.
- R7: For `b`=0 the returned `z` is 2^n−1 (all ones over the n low bits). No error indication is given.
- R8: The effective length n is min(`nbits`, W). An `nbits` above W behaves exactly like `nbits`=W.
- R9: A reset asserted while a division is running abandons it. The block comes back idle with `z`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Request operands are valid |
| inReady | output | 1 | Block is idle and will take a request |
| a | input | W | Dividend |
| b | input | W | Divisor |
| nbits | input | $clog2(W+1) | Requested quotient length |
| outValid | output | 1 | Quotient is valid |
| outReady | input | 1 | Consumer takes the quotient |
| z | output | W | Quotient |

## Verification
The hardest states to reach from the ports are the ones the bench cannot see directly. These are a running division whose input pins are changing under it, and a finished result being held while the consumer stalls. The bench sweeps every dividend, divisor and length for W=4, including lengths above W. During every run it keeps `inValid` high and puts corrupted operands on the pins. At each result it withholds `outReady` for a varying number of cycles, checking that `outValid` and `z` hold. A separate run is cut short by reset partway through.

// File: rtl/divu_pkg.sv
package divu_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} divState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;  // capture operands, clear remainder and quotient
    logic step;  // perform one conditional-subtraction iteration
  } divStrobe_t;
endpackage

// File: rtl/divu_ctrl.sv
module divu_ctrl
  import divu_pkg::*;
#(
  parameter int CNTW = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            inValid,
  input  logic            outReady,
  input  logic [CNTW-1:0] lenIn,
  output logic            inReady,
  output logic            outValid,
  output divStrobe_t      strobe
);
  divState_t       state;
  logic [CNTW-1:0] cnt;
  logic [CNTW-1:0] lenReg;
  logic            lastIter;

  assign lastIter = (cnt == lenReg - CNTW'(1));

  always_comb begin
    inReady     = (state == ST_IDLE);
    outValid    = (state == ST_DONE);
    strobe.load = (state == ST_IDLE) && inValid;
    strobe.step = (state == ST_RUN);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      lenReg <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (inValid) begin
          lenReg <= lenIn;
          cnt    <= '0;
          state  <= (lenIn == '0) ? ST_DONE : ST_RUN;
        end
        ST_RUN: begin
          cnt <= cnt + CNTW'(1);
          if (lastIter) state <= ST_DONE;
        end
        ST_DONE: if (outReady) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4: the iteration counter never passes the captured length while running
  a_r4_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN) |-> (cnt < lenReg));

  // R5: a held result stays held while the consumer stalls
  a_r5_done_hold: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DONE && !outReady) |=> (state == ST_DONE));

  // R6: an output transfer returns the controller to idle
  a_r6_return_idle: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DONE && outReady) |=> (state == ST_IDLE));
endmodule

// File: rtl/divu_path.sv
module divu_path
  import divu_pkg::*;
#(
  parameter int W    = 8,
  parameter int CNTW = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  divStrobe_t      strobe,
  input  logic [W-1:0]    aIn,
  input  logic [W-1:0]    bIn,
  input  logic [CNTW-1:0] lenIn,
  output logic [W-1:0]    z
);
  logic [W-1:0] dvdReg;
  logic [W-1:0] divReg;
  logic [W-1:0] remReg;
  logic [W-1:0] zReg;
  logic [W:0]   trial;
  logic         ge;
  logic [W-1:0] diff;

  always_comb begin
    trial = {remReg, dvdReg[W-1]};
    ge    = (trial >= {1'b0, divReg});
    diff  = trial[W-1:0] - divReg;  // fits in W bits whenever ge is set
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dvdReg <= '0;
      divReg <= '0;
      remReg <= '0;
      zReg   <= '0;
    end else if (strobe.load) begin
      // align the top bit of the active field with the MSB
      dvdReg <= aIn << (CNTW'(W) - lenIn);
      divReg <= bIn;
      remReg <= '0;
      zReg   <= '0;
    end else if (strobe.step) begin
      dvdReg <= dvdReg << 1;
      remReg <= ge ? diff : trial[W-1:0];
      zReg   <= {zReg[W-2:0], ge};
    end
  end

  assign z = zReg;

  // R3: partial remainder stays below a nonzero divisor
  a_r3_rem_below_div: assert property (@(posedge clk) disable iff (rst)
    (divReg != '0) |-> (remReg < divReg));
endmodule

// File: rtl/divu_core.sv
module divu_core
  import divu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     inValid,
  output logic                     inReady,
  input  logic [W-1:0]             a,
  input  logic [W-1:0]             b,
  input  logic [$clog2(W+1)-1:0]   nbits,
  output logic                     outValid,
  input  logic                     outReady,
  output logic [W-1:0]             z
);
  localparam int CNTW = $clog2(W + 1);

  divStrobe_t      strobe;
  logic [CNTW-1:0] lenEff;

  // R8: lengths above W are clamped to W
  assign lenEff = (nbits > CNTW'(W)) ? CNTW'(W) : nbits;

  divu_ctrl #(.CNTW(CNTW)) ctrl_i (
    .clk(clk), .rst(rst), .inValid(inValid), .outReady(outReady),
    .lenIn(lenEff), .inReady(inReady), .outValid(outValid), .strobe(strobe)
  );

  divu_path #(.W(W), .CNTW(CNTW)) path_i (
    .clk(clk), .rst(rst), .strobe(strobe), .aIn(a), .bIn(b),
    .lenIn(lenEff), .z(z)
  );

  // R5: result and valid flag hold under back-pressure
  a_r5_z_stable: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> (outValid && $stable(z)));

  // R5: never ready for input while a result is offered
  a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(inReady && outValid));

  // R2: an accepted request makes the block busy on the next cycle
  a_r2_accept_busy: assert property (@(posedge clk) disable iff (rst)
    (inReady && inValid) |=> !inReady);

  // R6: after an output transfer the block is ready again
  a_r6_ready_after_xfer: assert property (@(posedge clk) disable iff (rst)
    (outValid && outReady) |=> (inReady && !outValid));
endmodule

// File: tb/divu_core_tb.sv
`timescale 1ns/1ps
module divu_core_tb_top;
  localparam int W    = 4;
  localparam int CNTW = $clog2(W + 1);

  logic            clk = 1'b0;
  logic            rst;
  logic            inValid, inReady, outValid, outReady;
  logic [W-1:0]    a, b, z;
  logic [CNTW-1:0] nbits;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;  // 125 MHz

  divu_core #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
    .a(a), .b(b), .nbits(nbits), .outValid(outValid),
    .outReady(outReady), .z(z)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int expQ(input int av, input int bv, input int nv);
    int ne = (nv > W) ? W : nv;
    int am = av & ((1 << ne) - 1);
    if (bv == 0) return (1 << ne) - 1;  // R7
    return am / bv;                     // R3
  endfunction

  task automatic runOne(input int av, input int bv, input int nv, input int hold);
    int lat;
    int ne;
    int ez;
    ne = (nv > W) ? W : nv;
    ez = expQ(av, bv, nv);
    @(negedge clk);
    chk(inReady === 1'b1, "R6 ready before request", int'(inReady), 1);
    a = W'(av); b = W'(bv); nbits = CNTW'(nv); inValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    // R2: corrupt operands while busy, keep inValid high
    a = ~W'(av); b = W'(bv + 1); nbits = CNTW'(nv ^ 1);
    lat = 1;
    while (!outValid && lat < 40) begin
      chk(inReady === 1'b0, "R5 busy inReady", int'(inReady), 0);
      @(negedge clk);
      lat++;
    end
    inValid = 1'b0;
    chk(lat == ne + 1, (nv > W) ? "R8 latency" : "R4 latency", lat, ne + 1);
    chk(int'(z) == ez, (bv == 0) ? "R7 zero divisor" : (nv > W) ? "R8 quotient" : "R3 quotient",
        int'(z), ez);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(outValid === 1'b1 && int'(z) == ez && inReady === 1'b0, "R5 hold",
          int'(z), ez);
    end
    outReady = 1'b1;
    @(negedge clk);
    outReady = 1'b0;
    chk(inReady === 1'b1 && outValid === 1'b0, "R6 back to idle",
        int'({inReady, outValid}), 2);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; inValid = 1'b0; outReady = 1'b0; a = '0; b = '0; nbits = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(inReady === 1'b1 && outValid === 1'b0 && z === '0, "R1 reset state",
        int'({inReady, outValid}), 2);
    rst = 1'b0;

    // R3 R4 R7 R8: full sweep of operands and lengths, varying stall length
    for (int nv = 0; nv < (1 << CNTW); nv++)
      for (int av = 0; av < (1 << W); av++)
        for (int bv = 0; bv < (1 << W); bv++)
          runOne(av, bv, nv, (av + bv + nv) % 3);

    // R9: reset in the middle of a run
    @(negedge clk);
    a = 4'd13; b = 4'd3; nbits = CNTW'(W); inValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(inReady === 1'b1 && outValid === 1'b0 && z === '0, "R9 abort run",
        int'({inReady, outValid}), 2);
    runOne(13, 3, W, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule